// File: doc/BRIEF.md
# Dual-Context Byte DMA Channel for a Parallel Device

This block is one DMA channel that moves bytes between system memory and a byte-wide parallel device. Software describes up to two buffers, called context A and context B, through a small register port. It then sets their valid bits. The channel runs the valid buffers one after the other, alternating between the two slots. Software can therefore refill one slot while the channel works on the other.

Each buffer can ask for a single-cycle terminal-count pulse once its last byte has gone through. A buffer that would run past a 4 KB page is refused before any transfer starts. An input buffer whose base is not 64-byte aligned is refused in the same way. A read-only diagnostic word shows which slot is selected, whether the engine is busy, and how many bytes remain.

The register port has four 64-bit words and a read latency of one cycle. Memory is reached through a byte-wide request/grant port. Read data is valid in the cycle the grant is high. The device side is one valid/ready byte stream in each direction.

Top module: `pdma_channel`

## Requirements
- R1: Register word 0 holds context A and word 1 holds context B. Each context word has the last flag in bit 63, the length in bits 43:32 (byte count minus one) and the base address in bits 31:0. All other bits read back as zero. A read returns the addressed word one cycle after `reg_rd`.
- R2: With direction 0 (memory to device), the channel reads bytes from base, base+1, … up to base+length. It hands exactly length+1 bytes to the device, in address order.
- R3: With direction 1 (device to memory), the channel writes the bytes accepted from the device to base, base+1, … in arrival order. It writes exactly length+1 of them.
- R4: For a context whose last flag is 1, `tc_pulse` is high for exactly one cycle after the final byte has been accepted by the device (output) or granted to memory (input). For a context with last flag 0, no pulse is produced.
- R5: After reset the channel starts with context A. When a context finishes, its valid bit clears and the selection moves to the other slot. That slot runs if it is valid; otherwise the channel idles until a valid bit is set.
- R6: A context with base[11:0] + length above 4095 is not run and moves no data. Its valid bit clears, sticky error bit 5 of word 2 sets, and the channel moves to the other slot.
- R7: An input context whose base[5:0] is non-zero is refused as in R6. An output context may start at any byte address.
- R8: While enable (word 2 bit 1) is 0, `mem_req`, `tx_valid` and `rx_ready` stay low and the diagnostic active bit reads 0. Position and byte count are held. The transfer resumes at the next byte when enable returns to 1.
- R9: Word 3 reads as follows: bit 0 is the selected slot (0 = A), bit 1 is "enabled and busy", and bits 13:2 hold the remaining byte count minus one (0 when idle). Writes to word 3 have no effect.
- R10: Writing word 2 with bit 2 set aborts the channel. It clears both valid bits, the error bit, the byte count, the selected slot, the busy bit and any pending terminal count. Bit 2 always reads back as 0.
- R11: After the reset input, all register words read as zero and the memory and device outputs are idle.
- R12: A context with length 0xFFF at a page-aligned base covers a full page and is run. The same length at base+1 is refused.
- R13: Writing word 2 with bit 5 set clears the sticky error bit. Word 2 bit 0 is direction, bit 3 is context B valid and bit 4 is context A valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register word select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 64 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 64 | Register read data, one cycle after `reg_rd` |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_gnt | input | 1 | Memory grant; completes the request |
| mem_rdata | input | 8 | Memory read byte, valid with `mem_gnt` |
| tx_valid | output | 1 | Byte to device is valid |
| tx_data | output | 8 | Byte to device |
| tx_ready | input | 1 | Device accepts byte |
| rx_valid | input | 1 | Byte from device is valid |
| rx_data | input | 8 | Byte from device |
| rx_ready | output | 1 | Channel accepts byte |
| tc_pulse | output | 1 | Terminal-count pulse |

## Verification
A corrupted address or count register would show up at the device or memory port within one byte. A wrong address gives the wrong data byte or write address. A wrong count gives an extra byte, or a missing one, at the end of the buffer. A wrong slot selection or a wrong valid-bit update shows up as bytes from the wrong buffer, or in the wrong buffer order, the first time both slots are valid. It also shows up in the word 2 and word 3 readback taken after each buffer. Freeze and abort faults show as handshakes or requests during the frozen or aborted window, or as a diagnostic count that does not match the number of bytes already seen at the device.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

  localparam int CTX_LEN_W   = 12;
  localparam int CTX_ADDR_W  = 32;
  localparam int CTX_LAST_B  = 63;
  localparam int CTX_LEN_LSB = 32;

  localparam logic [1:0] RA_CTX_A = 2'd0;
  localparam logic [1:0] RA_CTX_B = 2'd1;
  localparam logic [1:0] RA_CTL   = 2'd2;
  localparam logic [1:0] RA_DIAG  = 2'd3;

  localparam int CB_DIR   = 0;
  localparam int CB_EN    = 1;
  localparam int CB_ABORT = 2;
  localparam int CB_VB    = 3;
  localparam int CB_VA    = 4;
  localparam int CB_ERR   = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_FETCH, ST_SEND, ST_RECV, ST_WRITE, ST_DONE
  } eng_state_t;

  typedef struct packed {
    logic                  last;
    logic [CTX_LEN_W-1:0]  len;
    logic [CTX_ADDR_W-1:0] base;
  } ctx_t;

  function automatic ctx_t unpack_ctx(input logic [63:0] w);
    ctx_t c;
    c.last = w[CTX_LAST_B];
    c.len  = w[CTX_LEN_LSB +: CTX_LEN_W];
    c.base = w[CTX_ADDR_W-1:0];
    return c;
  endfunction

  function automatic logic [63:0] pack_ctx(input ctx_t c);
    logic [63:0] w;
    w = '0;
    w[CTX_LAST_B] = c.last;
    w[CTX_LEN_LSB +: CTX_LEN_W] = c.len;
    w[CTX_ADDR_W-1:0] = c.base;
    return w;
  endfunction

endpackage

// File: rtl/pdma_ctx_check.sv
module pdma_ctx_check
  import pdma_pkg::*;
#(
  parameter int PAGE_BITS     = 12,
  parameter int IN_ALIGN_BITS = 6
) (
  input  ctx_t ctx,
  input  logic dir_in,
  output logic ok
);
  localparam int SUM_W = PAGE_BITS + 1;

  logic [SUM_W-1:0] end_off;
  logic             page_bad;
  logic             align_bad;

  assign end_off  = {1'b0, ctx.base[PAGE_BITS-1:0]} + SUM_W'(ctx.len);
  assign page_bad = end_off[PAGE_BITS];

  generate
    if (IN_ALIGN_BITS == 0) begin : g_no_align
      assign align_bad = 1'b0;
    end else begin : g_align
      assign align_bad = dir_in && (ctx.base[IN_ALIGN_BITS-1:0] != '0);
    end
  endgenerate

  assign ok = !page_bad && !align_bad;

endmodule

// File: rtl/pdma_regs.sv
module pdma_regs
  import pdma_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [63:0]      reg_wdata,
  input  logic             reg_rd,
  output logic [63:0]      reg_rdata,
  input  logic             clr_a,
  input  logic             clr_b,
  input  logic             err_set,
  input  logic             diag_sel,
  input  logic             diag_active,
  input  logic [CNT_W-1:0] diag_count,
  output ctx_t             ctx_a,
  output ctx_t             ctx_b,
  output logic             dir,
  output logic             en,
  output logic             valid_a,
  output logic             valid_b,
  output logic             abort
);
  logic ctl_wr;
  logic err;

  assign ctl_wr = reg_wr && (reg_addr == RA_CTL);
  assign abort  = ctl_wr && reg_wdata[CB_ABORT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctx_a <= '0;
      ctx_b <= '0;
    end else if (reg_wr) begin
      if (reg_addr == RA_CTX_A) ctx_a <= unpack_ctx(reg_wdata);
      if (reg_addr == RA_CTX_B) ctx_b <= unpack_ctx(reg_wdata);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir     <= 1'b0;
      en      <= 1'b0;
      valid_a <= 1'b0;
      valid_b <= 1'b0;
      err     <= 1'b0;
    end else begin
      if (clr_a) valid_a <= 1'b0;
      if (clr_b) valid_b <= 1'b0;
      if (ctl_wr) begin
        dir     <= reg_wdata[CB_DIR];
        en      <= reg_wdata[CB_EN];
        valid_a <= reg_wdata[CB_VA];
        valid_b <= reg_wdata[CB_VB];
        if (reg_wdata[CB_ERR]) err <= 1'b0;
      end
      if (err_set) err <= 1'b1;
      if (abort) begin
        valid_a <= 1'b0;
        valid_b <= 1'b0;
        err     <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      unique case (reg_addr)
        RA_CTX_A: reg_rdata <= pack_ctx(ctx_a);
        RA_CTX_B: reg_rdata <= pack_ctx(ctx_b);
        RA_CTL:   reg_rdata <= 64'({err, valid_a, valid_b, 1'b0, en, dir});
        default:  reg_rdata <= 64'({diag_count, diag_active, diag_sel});
      endcase
    end
  end

  a_r10_abort_clears: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!valid_a && !valid_b && !err));

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst || abort)
    err_set |=> err);

endmodule

// File: rtl/pdma_engine.sv
module pdma_engine
  import pdma_pkg::*;
#(
  parameter int PAGE_BITS     = 12,
  parameter int IN_ALIGN_BITS = 6,
  parameter int ADDR_W        = 32,
  parameter int DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              en,
  input  logic              dir,
  input  logic              valid_a,
  input  logic              valid_b,
  input  ctx_t              ctx_a,
  input  ctx_t              ctx_b,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              clr_a,
  output logic              clr_b,
  output logic              err_set,
  output logic              tc_pulse,
  output logic              sel,
  output logic              active,
  output logic [PAGE_BITS-1:0] count
);
  eng_state_t          st;
  logic [ADDR_W-1:0]   cur_addr;
  logic [PAGE_BITS-1:0] cnt;
  logic [DATA_W-1:0]   hold;
  logic                last_f;
  logic                tc_q;
  logic                cur_valid;
  logic                oth_valid;
  ctx_t                cur_ctx;
  logic                ctx_ok;
  logic                finish;
  logic                reject;
  logic                xfer;

  assign cur_valid = sel ? valid_b : valid_a;
  assign oth_valid = sel ? valid_a : valid_b;
  assign cur_ctx   = sel ? ctx_b : ctx_a;

  pdma_ctx_check #(
    .PAGE_BITS    (PAGE_BITS),
    .IN_ALIGN_BITS(IN_ALIGN_BITS)
  ) u_check (
    .ctx   (cur_ctx),
    .dir_in(dir),
    .ok    (ctx_ok)
  );

  assign finish  = en && (st == ST_DONE);
  assign reject  = en && (st == ST_CHECK) && !ctx_ok;
  assign clr_a   = (finish || reject) && !sel;
  assign clr_b   = (finish || reject) && sel;
  assign err_set = reject;
  assign xfer    = (st == ST_FETCH) || (st == ST_SEND) ||
                   (st == ST_RECV)  || (st == ST_WRITE);

  always_ff @(posedge clk) begin
    tc_q <= 1'b0;
    if (rst || abort) begin
      st       <= ST_IDLE;
      sel      <= 1'b0;
      cur_addr <= '0;
      cnt      <= '0;
      hold     <= '0;
      last_f   <= 1'b0;
    end else if (en) begin
      unique case (st)
        ST_IDLE: begin
          if (cur_valid) begin
            st <= ST_CHECK;
          end else if (oth_valid) begin
            sel <= ~sel;
            st  <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (!ctx_ok) begin
            sel <= ~sel;
            st  <= ST_IDLE;
          end else begin
            cur_addr <= cur_ctx.base[ADDR_W-1:0];
            cnt      <= cur_ctx.len[PAGE_BITS-1:0];
            last_f   <= cur_ctx.last;
            st       <= dir ? ST_RECV : ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_gnt) begin
            hold <= mem_rdata;
            st   <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (tx_ready) begin
            if (cnt == '0) begin
              st <= ST_DONE;
            end else begin
              cnt      <= cnt - 1'b1;
              cur_addr <= cur_addr + 1'b1;
              st       <= ST_FETCH;
            end
          end
        end
        ST_RECV: begin
          if (rx_valid) begin
            hold <= rx_data;
            st   <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (mem_gnt) begin
            if (cnt == '0) begin
              st <= ST_DONE;
            end else begin
              cnt      <= cnt - 1'b1;
              cur_addr <= cur_addr + 1'b1;
              st       <= ST_RECV;
            end
          end
        end
        ST_DONE: begin
          tc_q <= last_f;
          sel  <= ~sel;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign mem_req   = en && ((st == ST_FETCH) || (st == ST_WRITE));
  assign mem_we    = (st == ST_WRITE);
  assign mem_addr  = cur_addr;
  assign mem_wdata = hold;
  assign tx_valid  = en && (st == ST_SEND);
  assign tx_data   = hold;
  assign rx_ready  = en && (st == ST_RECV);
  assign tc_pulse  = tc_q;
  assign active    = en && (st != ST_IDLE);
  assign count     = cnt;

  a_r4_tc_single: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |=> !tc_pulse);

  a_r8_freeze_hold: assert property (@(posedge clk) disable iff (rst || abort)
    (!en && st != ST_IDLE) |=> ($stable(cnt) && $stable(cur_addr) && $stable(sel)));

  a_r9_count_down: assert property (@(posedge clk) disable iff (rst || abort)
    xfer |=> (cnt <= $past(cnt)));

  a_r8_no_req_frozen: assert property (@(posedge clk) disable iff (rst)
    (!en && $past(!en)) |-> (!tx_valid && !rx_ready && !mem_req));

endmodule

// File: rtl/pdma_channel.sv
module pdma_channel
  import pdma_pkg::*;
#(
  parameter int PAGE_BITS     = 12,
  parameter int IN_ALIGN_BITS = 6,
  parameter int ADDR_W        = 32,
  parameter int DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [63:0]       reg_wdata,
  input  logic              reg_rd,
  output logic [63:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tc_pulse
);
  ctx_t                 ctx_a, ctx_b;
  logic                 dir, en, valid_a, valid_b, abort;
  logic                 clr_a, clr_b, err_set;
  logic                 sel, active;
  logic [PAGE_BITS-1:0] count;

  pdma_regs #(.CNT_W(PAGE_BITS)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rd     (reg_rd),
    .reg_rdata  (reg_rdata),
    .clr_a      (clr_a),
    .clr_b      (clr_b),
    .err_set    (err_set),
    .diag_sel   (sel),
    .diag_active(active),
    .diag_count (count),
    .ctx_a      (ctx_a),
    .ctx_b      (ctx_b),
    .dir        (dir),
    .en         (en),
    .valid_a    (valid_a),
    .valid_b    (valid_b),
    .abort      (abort)
  );

  pdma_engine #(
    .PAGE_BITS    (PAGE_BITS),
    .IN_ALIGN_BITS(IN_ALIGN_BITS),
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W)
  ) u_engine (
    .clk      (clk),
    .rst      (rst),
    .abort    (abort),
    .en       (en),
    .dir      (dir),
    .valid_a  (valid_a),
    .valid_b  (valid_b),
    .ctx_a    (ctx_a),
    .ctx_b    (ctx_b),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_gnt  (mem_gnt),
    .mem_rdata(mem_rdata),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_ready (tx_ready),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .rx_ready (rx_ready),
    .clr_a    (clr_a),
    .clr_b    (clr_b),
    .err_set  (err_set),
    .tc_pulse (tc_pulse),
    .sel      (sel),
    .active   (active),
    .count    (count)
  );

endmodule

// File: tb/pdma_channel_bench.sv
`timescale 1ns/1ps
module pdma_channel_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [63:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [63:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_gnt = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic        tc_pulse;

  always #10 clk = ~clk;

  pdma_channel u_pdma_channel (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tc_pulse(tc_pulse)
  );

  int nchk = 0, nerr = 0, tc_cnt = 0, tx_seen = 0;
  bit tx_stall = 1'b0, done = 1'b0;
  logic [7:0]  mem [0:8191];
  logic [7:0]  tx_exp [$];
  logic [39:0] wr_exp [$];
  logic [7:0]  rx_src [$];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  task automatic wr(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [63:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  function automatic logic [63:0] ctx(input bit last, input logic [11:0] len, input logic [31:0] base);
    return {last, 19'b0, len, base};
  endfunction

  // driver: expected device bytes for an output buffer
  task automatic push_out(input logic [31:0] base, input int len);
    for (int i = 0; i <= len; i++) tx_exp.push_back(mem[13'(base + i)]);
  endtask

  // driver: device bytes and expected memory writes for an input buffer
  task automatic push_in(input logic [31:0] base, input int len, input logic [7:0] seed);
    for (int i = 0; i <= len; i++) begin
      logic [7:0] b;
      b = seed + 8'(i * 5);
      rx_src.push_back(b);
      wr_exp.push_back({base + 32'(i), b});
    end
  endtask

  task automatic wait_idle();
    logic [63:0] d;
    repeat (4) @(negedge clk);
    while (tx_exp.size() != 0 || wr_exp.size() != 0) @(negedge clk);
    d = 64'h2;
    while (d[1]) rd(2'd3, d);
    repeat (4) @(negedge clk);
  endtask

  // memory model and write monitor
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c++;
      mem_gnt = 1'b0;
      if (mem_req && (c % 3 != 0)) begin
        mem_gnt = 1'b1;
        if (mem_we) begin
          if (wr_exp.size() == 0) chk("R3 unexpected write", {mem_addr, mem_wdata}, 40'h0);
          else chk("R3 write", {mem_addr, mem_wdata}, wr_exp.pop_front());
          mem[mem_addr[12:0]] = mem_wdata;
        end else begin
          mem_rdata = mem[mem_addr[12:0]];
        end
      end
    end
  end

  // device sink monitor
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c++;
      tx_ready = !tx_stall && (c % 4 != 1);
      if (tx_valid && tx_ready) begin
        tx_seen++;
        if (tx_exp.size() == 0) chk("R2 unexpected byte", {56'b0, tx_data}, 64'hFFFF);
        else chk("R2 byte", {56'b0, tx_data}, {56'b0, tx_exp.pop_front()});
      end
    end
  end

  // device source
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c++;
      rx_valid = (rx_src.size() != 0) && (c % 5 != 2);
      rx_data  = (rx_src.size() != 0) ? rx_src[0] : 8'h00;
      if (rx_valid && rx_ready) void'(rx_src.pop_front());
    end
  end

  initial forever begin
    @(negedge clk);
    if (tc_pulse) tc_cnt++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [63:0] d;
    int s0, t0;
    for (int i = 0; i < 8192; i++) mem[i] = 8'(i * 7 + 3);
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R11: reset state
    rd(2'd2, d); chk("R11 ctl after reset", d, 64'h0);
    rd(2'd3, d); chk("R11 diag after reset", d, 64'h0);
    rd(2'd0, d); chk("R11 ctxA after reset", d, 64'h0);
    chk("R11 outputs idle", {61'b0, mem_req, tx_valid, tc_pulse}, 64'h0);

    // R2 R4 R7: output from an unaligned base, last flag set
    wr(2'd0, ctx(1'b1, 12'd5, 32'h103));
    push_out(32'h103, 5);
    wr(2'd2, 64'h12);
    wait_idle();
    chk("R2 all bytes delivered", 64'(tx_exp.size()), 64'h0);
    chk("R4 one pulse", 64'(tc_cnt), 64'd1);
    rd(2'd2, d); chk("R5 valid A cleared", d, 64'h02);
    rd(2'd3, d); chk("R5 R9 selection moved to B", d, 64'h1);

    // R5: both valid, selection is B so B runs first
    wr(2'd0, ctx(1'b0, 12'd3, 32'h200));
    wr(2'd1, ctx(1'b1, 12'd2, 32'h300));
    push_out(32'h300, 2);
    push_out(32'h200, 3);
    wr(2'd2, 64'h1A);
    wait_idle();
    chk("R4 pulse only for flagged buffer", 64'(tc_cnt), 64'd2);
    rd(2'd2, d); chk("R5 both valid cleared", d, 64'h02);
    rd(2'd3, d); chk("R5 selection after two", d, 64'h1);

    // R3 R4: input into context B at aligned base
    wr(2'd1, ctx(1'b1, 12'd3, 32'hC40));
    push_in(32'hC40, 3, 8'hA0);
    wr(2'd2, 64'h0B);
    wait_idle();
    chk("R3 writes done", 64'(wr_exp.size()), 64'h0);
    chk("R3 last byte stored", {56'b0, mem[13'hC43]}, 64'hAF);
    chk("R4 pulse after input", 64'(tc_cnt), 64'd3);

    // R6: page crossing in A is refused, B runs
    wr(2'd0, ctx(1'b1, 12'h020, 32'hFF0));
    wr(2'd1, ctx(1'b0, 12'd1, 32'h400));
    push_out(32'h400, 1);
    wr(2'd2, 64'h1A);
    wait_idle();
    rd(2'd2, d); chk("R6 error set, valids clear", d, 64'h22);
    chk("R6 no pulse for refused buffer", 64'(tc_cnt), 64'd3);

    // R13: error write-one-to-clear
    wr(2'd2, 64'h22);
    rd(2'd2, d); chk("R13 error cleared", d, 64'h02);

    // R7: misaligned input in A refused
    wr(2'd0, ctx(1'b1, 12'd3, 32'hC44));
    wr(2'd2, 64'h13);
    wait_idle();
    rd(2'd2, d); chk("R7 misaligned input refused", d, 64'h23);
    chk("R7 no pulse", 64'(tc_cnt), 64'd3);
    wr(2'd2, 64'h22);

    // R12: full page accepted in B, base+1 refused in A
    wr(2'd1, ctx(1'b1, 12'hFFF, 32'h1000));
    push_out(32'h1000, 4095);
    wr(2'd2, 64'h0A);
    wait_idle();
    chk("R12 full page delivered", 64'(tx_exp.size()), 64'h0);
    chk("R12 full page pulse", 64'(tc_cnt), 64'd4);
    rd(2'd2, d); chk("R12 full page no error", d, 64'h02);
    wr(2'd0, ctx(1'b1, 12'hFFF, 32'h1001));
    wr(2'd2, 64'h12);
    wait_idle();
    rd(2'd2, d); chk("R12 page+1 refused", d, 64'h22);
    wr(2'd2, 64'h22);

    // R8 R9: freeze mid-buffer in B and resume
    wr(2'd1, ctx(1'b1, 12'h01F, 32'h500));
    push_out(32'h500, 31);
    s0 = tx_seen;
    wr(2'd2, 64'h0A);
    while (tx_seen < s0 + 10) @(negedge clk);
    wr(2'd2, 64'h08);
    repeat (2) @(negedge clk);
    t0 = tx_seen;
    rd(2'd3, d);
    chk("R8 R9 frozen diag", d, {50'b0, 12'(31 - (t0 - s0)), 1'b0, 1'b1});
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mem_req || tx_valid) chk("R8 request while frozen", {62'b0, mem_req, tx_valid}, 64'h0);
    end
    chk("R8 no bytes while frozen", 64'(tx_seen), 64'(t0));
    rd(2'd3, d);
    chk("R8 count held", d, {50'b0, 12'(31 - (t0 - s0)), 1'b0, 1'b1});
    wr(2'd2, 64'h0A);
    wait_idle();
    chk("R8 resumed to end", 64'(tx_exp.size()), 64'h0);
    chk("R8 pulse after resume", 64'(tc_cnt), 64'd5);

    // R9 R10: busy diag, then abort
    tx_stall = 1'b1;
    wr(2'd0, ctx(1'b1, 12'h03F, 32'h600));
    wr(2'd2, 64'h12);
    repeat (20) @(negedge clk);
    rd(2'd3, d); chk("R9 busy diag", d, 64'hFE);
    wr(2'd2, 64'h06);
    rd(2'd2, d); chk("R10 abort readback", d, 64'h02);
    rd(2'd3, d); chk("R10 diag cleared", d, 64'h0);
    t0 = tx_seen;
    tx_stall = 1'b0;
    repeat (20) @(negedge clk);
    chk("R10 no bytes after abort", 64'(tx_seen), 64'(t0));
    chk("R10 no pulse after abort", 64'(tc_cnt), 64'd5);

    // R9: diag writes ignored; R1: context field layout
    wr(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(2'd3, d); chk("R9 diag read-only", d, 64'h0);
    wr(2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(2'd0, d); chk("R1 ctx field layout", d, 64'h8000_0FFF_FFFF_FFFF);
    rd(2'd2, d); chk("R1 ctx write does not start", d, 64'h02);

    done = 1'b1;
    finish_run();
  end

endmodule